// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block generates the array address for a four-beat burst in a synchronous burst SRAM. When an access starts, the full address is captured; the two least significant bits become the first beat of the burst, and the upper bits are held unchanged for the whole burst. Each clock edge with the active-low advance input driven low moves the two low bits to the next beat.

Two beat orders are offered, selected by a static order input. In linear order the low bits count up by one and wrap modulo four. In interleaved order the low bits equal the starting value XOR the beat index, and the beat index counts 0 to 3 and wraps. A start overrides advance in the same cycle. With neither start nor advance, the address holds. The same sequencer serves read and write bursts, because it only produces addresses.

Top module: `burst_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `addr_out` is all zeros.
- R2: A clock edge with `start` high loads `addr_in` into `addr_out` (all bits, visible after that edge), whatever `adv_n` is.
- R3: A clock edge with `start` low and `adv_n` high leaves `addr_out` unchanged.
- R4: With `lin_order` = 1, an edge with `start` low and `adv_n` low sets `addr_out[1:0]` to its previous value plus one, modulo 4 (3 wraps to 0).
- R5: With `lin_order` = 0, after a start at low value S and k advances, `addr_out[1:0]` = S XOR (k mod 4). For example, S = 2 gives 2, 3, 0, 1.
- R6: In either order, four advances after a start return `addr_out[1:0]` to the start value, and the four beats cover all four low addresses.
- R7: While no start occurs, `addr_out[ADDR_W-1:2]` stays equal to the value loaded at the last start, advances included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new access, loading `addr_in` |
| adv_n | input | 1 | Advance to the next beat when low |
| lin_order | input | 1 | Beat order: 1 linear, 0 interleaved |
| addr_in | input | ADDR_W | Address presented at access start |
| addr_out | output | ADDR_W | Address to the memory array |

## Verification
Every start value 0 to 3 is run through a full burst and one beat past the wrap, in both orders. Start values 1 and 3 separate the two orders, because there linear and interleaved sequences disagree on beats 1 and 3. Advances interleaved with idle cycles show that a hold does not disturb the beat index. Cycles with start and advance both low, and a start with advance low in the same cycle, show which input takes priority.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv_n,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UP_W = ADDR_W - 2;

  logic [UP_W-1:0] upper_q;
  logic [1:0]      base_q;
  logic [1:0]      beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
      beat_q  <= '0;
    end else if (start) begin
      upper_q <= addr_in[ADDR_W-1:2];
      base_q  <= addr_in[1:0];
      beat_q  <= '0;
    end else if (!adv_n) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  wire [1:0] lin_low = base_q + beat_q;
  wire [1:0] ilv_low = base_q ^ beat_q;

  assign addr_out = {upper_q, lin_order ? lin_low : ilv_low};
endmodule

module burst_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              adv_n,
  input logic              lin_order,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr_out == $past(addr_in));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && adv_n) |=> ($stable(lin_order) -> $stable(addr_out)));

  p_step_lin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !adv_n && lin_order) |=>
      (lin_order -> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  p_toggle_ilv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !adv_n && !lin_order) |=>
      (!lin_order -> addr_out[0] != $past(addr_out[0])));

  p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

  always_comb
    if (!rst_n) a_reset_zero_r1: assert (addr_out == '0);
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  localparam int AW = 20;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic          adv_n = 1;
  logic          lin_order = 1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int n_cmp = 0;
  int n_bad = 0;

  int m_upper = 0;
  int m_start = 0;
  int m_beat = 0;
  int m_lin = 0;

  always #2 clk = ~clk;

  burst_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .adv_n(adv_n),
    .lin_order(lin_order), .addr_in(addr_in), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] model_addr();
    int low;
    if (lin_order) low = m_lin;
    else low = m_start ^ m_beat;
    return {m_upper[AW-3:0], low[1:0]};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] exp);
    n_cmp++;
    if (addr_out !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h expected=%h at %0t", tag, addr_out, exp, $time);
    end
  endtask

  task automatic step(input logic st, input logic an, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    start = st; adv_n = an; addr_in = a;
    @(posedge clk);
    if (st) begin
      m_upper = int'(a[AW-1:2]);
      m_start = int'(a[1:0]);
      m_beat = 0;
      m_lin = m_start;
    end else if (!an) begin
      m_beat = (m_beat + 1) % 4;
      m_lin = (m_lin + 1) % 4;
    end
    #1;
    check(tag, model_addr());
  endtask

  int ilv_tab [4][4] = '{'{0,1,2,3}, '{1,0,3,2}, '{2,3,0,1}, '{3,2,1,0}};

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1;
    check("R1 in reset", '0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 after reset", '0);

    for (int m = 0; m < 2; m++) begin
      lin_order = (m == 1);
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {18'h2A5C3 + 18'(s * 7), 2'(s)};
        step(1, 1, a, "R2 load");
        check("R2 loaded value", a);
        for (int k = 1; k <= 4; k++) begin
          int e;
          step(0, 0, '0, lin_order ? "R4 linear step" : "R5 interleaved step");
          e = lin_order ? (s + k) % 4 : ilv_tab[s][k % 4];
          check(lin_order ? "R4 fixed seq" : "R5 fixed seq", {a[AW-1:2], 2'(e)});
          check("R7 upper kept", {a[AW-1:2], addr_out[1:0]});
        end
        check("R6 wrap to start", a);
        step(0, 0, '0, "R6 past wrap");
        step(0, 1, '0, "R3 hold");
        step(0, 1, '0, "R3 hold again");
      end
    end

    lin_order = 0;
    step(1, 1, {18'h1, 2'd1}, "R2 load");
    step(0, 0, '0, "R5 beat1");
    step(0, 1, '0, "R3 hold mid burst");
    step(0, 1, '0, "R3 hold mid burst");
    step(0, 0, '0, "R5 beat2 after hold");
    check("R5 beat2 value", {18'h1, 2'd3});
    step(1, 0, {18'h3FFFF, 2'd3}, "R2 start overrides advance");
    check("R2 override value", {18'h3FFFF, 2'd3});
    step(0, 0, '0, "R5 beat1 from 3");
    check("R5 beat1 value", {18'h3FFFF, 2'd2});

    lin_order = 1;
    step(1, 0, {18'h0, 2'd3}, "R2 start overrides advance");
    step(0, 0, '0, "R4 wrap 3 to 0");
    check("R4 wrap value", {18'h0, 2'd0});
    for (int i = 0; i < 40; i++)
      step(i % 5 == 0, (i % 3) == 1, AW'(i * 13 + 5), "R3 R4 mixed");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule